// File: doc/BRIEF.md
# Serial Frame Bus Access Arbiter

This block lets one device win, hold and give up shared use of the control and signalling channels of a frame-based serial bus. All devices share one open-drain line, so the line reads the wired-AND of every driver. Once per frame, in a fixed octet, the block reads a shared busy flag. It then contends by sending its programmed device address one bit at a time and reading the line back after each bit. The lowest address wins, because a 0 overrides a 1. Once it owns the bus, the block pulls the busy flag low in every frame until software withdraws its request.

Software controls the block with a request bit and a 3-bit device address. The block reports a per-frame grant flag. It also reports a stop/go status for the D channel, which it samples at the same bit position on a second serial input. A device that has just given up the bus is pushed into a lower priority class for a few frames, so that other devices get their turn. A device programmed with the all-ones address owns the bus whenever nobody else does.

Top module: `cbus_arbiter`

## Requirements
- R1: A synchronous active-high reset drives grant to 0 and dch_stop to 1, leaves line_out at 1, and clears both ownership and the lower-priority state. The first eligible frame after reset may contend at once.
- R2: The arbitration octet starts at bit OCTET_POS after frame_sync. The octet is sent bit 7 first, so octet bit 5 (the busy flag) sits at OCTET_POS+2 and the address bits sit at OCTET_POS+3 to OCTET_POS+5, most significant bit first. At every other bit position line_out is 1.
- R3: When acc_req is 1, the busy flag reads 1 (free) and the block is eligible, the block sends dev_addr in that frame's address field.
- R4: If the block sends a 1 and reads back a 0 during the address field, it loses. It drives 1 for the rest of the frame and gains no grant.
- R5: If all address bits are read back as sent, the block owns the bus. grant is 1 for the whole of every following frame in which it owns the bus.
- R6: While it owns the bus and acc_req is 1, the block drives the busy flag to 0 and sends its address. If acc_req is 0 at the busy flag slot, it drives 1, releases the bus, and grant falls at the next frame_sync.
- R7: If the busy flag reads 0 (occupied), the block does not contend in that frame.
- R8: After a release, the block may contend again only in a frame whose busy flag reads free when the previous frame's flag also read free. The release frame itself does not count, and a frame that reads busy restarts the count.
- R9: A block with dev_addr = 7 that reads a free flag and an address field of 7 raises grant in the next frame, even with no request.
- R10: dch_stop takes the value of stopgo_in at the busy flag bit position (1 = stop, 0 = go) and holds it until the next frame.
- R11: grant changes only on the clock edge that ends a frame_sync cycle, or on reset.
- R12: While acc_req is 0, a block that does not own the bus never drives the line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High in the cycle of bit 0 of each frame |
| acc_req | input | 1 | Software access request |
| dev_addr | input | 3 | Programmed device address |
| line_in | input | 1 | Resolved wired-AND line value |
| line_out | output | 1 | Open-drain drive, 1 is recessive |
| stopgo_in | input | 1 | Second serial line carrying the D-channel status |
| grant | output | 1 | High during every frame the device holds access |
| dch_stop | output | 1 | D-channel status: 1 stop, 0 go |

## Verification
The assertions check four things on every cycle: the line stays recessive outside the flag and address slots, the busy flag is pulled low only by a granted and still-requesting owner, grant moves only at frame boundaries, and the stop/go status follows its sample slot. Only the bench's frame sequences can show that the right device wins. The same goes for losing mid-address, the two-free-frame back-off and its restart on a busy frame, and default ownership at address 7, because each of these depends on what other devices put on the line over several frames.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
   // offsets inside the arbitration octet, octet sent bit 7 first
   localparam int FLAG_OFS = 2;   // octet bit 5
   localparam int ADDR_OFS = 3;   // octet bits 4 down to 2

   typedef enum logic [1:0] {
      ARB_IDLE    = 2'd0,
      ARB_CONTEND = 2'd1,
      ARB_OWN     = 2'd2
   } arb_state_e;
endpackage

// File: rtl/cbus_slot_timer.sv
module cbus_slot_timer #(
   parameter int FRAME_BITS = 32,
   parameter int OCTET_POS  = 16,
   parameter int ADDR_W     = 3,
   localparam int PW = $clog2(FRAME_BITS),
   localparam int IW = $clog2(ADDR_W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          frame_sync,
   output logic          at_flag,
   output logic          at_addr,
   output logic          addr_last,
   output logic [IW-1:0] addr_idx
);
   import cbus_pkg::*;

   localparam int FLAG_POS = OCTET_POS + FLAG_OFS;
   localparam int ADDR_POS = OCTET_POS + ADDR_OFS;
   localparam int ADDR_END = ADDR_POS + ADDR_W - 1;

   logic [PW-1:0] pos_q, pos;
   logic          synced, live;

   always_comb begin
      if (frame_sync)                       pos = '0;
      else if (pos_q == PW'(FRAME_BITS - 1)) pos = '0;
      else                                  pos = pos_q + 1'b1;
   end

   assign live = frame_sync | synced;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         synced <= 1'b0;
      end else begin
         pos_q <= pos;
         if (frame_sync) synced <= 1'b1;
      end
   end

   assign at_flag   = live && (pos == PW'(FLAG_POS));
   assign at_addr   = live && (pos >= PW'(ADDR_POS)) && (pos <= PW'(ADDR_END));
   assign addr_last = live && (pos == PW'(ADDR_END));
   assign addr_idx  = IW'(pos - PW'(ADDR_POS));
endmodule

// File: rtl/cbus_prio_gate.sv
module cbus_prio_gate #(
   parameter int FREE_FRAMES = 2,
   localparam int CW = $clog2(FREE_FRAMES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic at_flag,
   input  logic line_in,
   input  logic release_i,
   output logic prio_ok
);
   logic          low_prio;
   logic [CW-1:0] free_cnt;
   logic          last_needed;

   assign last_needed = (free_cnt == CW'(FREE_FRAMES - 1));
   assign prio_ok     = !low_prio || (line_in && last_needed);

   always_ff @(posedge clk) begin
      if (rst) begin
         low_prio <= 1'b0;
         free_cnt <= '0;
      end else if (release_i) begin
         low_prio <= 1'b1;
         free_cnt <= '0;
      end else if (at_flag && low_prio) begin
         if (!line_in) begin
            free_cnt <= '0;
         end else if (last_needed) begin
            low_prio <= 1'b0;
            free_cnt <= '0;
         end else begin
            free_cnt <= free_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbus_contend.sv
module cbus_contend #(
   parameter int ADDR_W        = 3,
   parameter bit MSB_FIRST     = 1'b1,
   parameter bit DEFAULT_OWNER = 1'b1,
   localparam int IW = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              at_flag,
   input  logic              at_addr,
   input  logic              addr_last,
   input  logic [IW-1:0]     addr_idx,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic              line_in,
   input  logic              prio_ok,
   output logic              line_out,
   output logic              own,
   output logic              release_o,
   output logic              dflt_hit
);
   import cbus_pkg::*;

   arb_state_e        state;
   logic              lost, lost_next, flag_free, my_bit, dflt_cond;
   logic [IW-1:0]     sel;
   logic [ADDR_W-1:0] obs_q, obs_full;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sel = IW'(ADDR_W - 1) - addr_idx;
      end else begin : g_lsb
         assign sel = addr_idx;
      end
   endgenerate

   assign my_bit   = dev_addr[sel];
   assign obs_full = {obs_q[ADDR_W-2:0], line_in};
   assign own      = (state == ARB_OWN);

   generate
      if (DEFAULT_OWNER) begin : g_dflt
         assign dflt_cond = flag_free && !own && (&obs_full) && (&dev_addr);
      end else begin : g_no_dflt
         assign dflt_cond = 1'b0;
      end
   endgenerate

   assign lost_next = lost | (my_bit & ~line_in);
   assign release_o = at_flag && own && !acc_req;

   always_comb begin
      line_out = 1'b1;
      if (at_flag) begin
         if (own && acc_req) line_out = 1'b0;
      end else if (at_addr) begin
         if (own || (state == ARB_CONTEND && !lost)) line_out = my_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ARB_IDLE;
         lost      <= 1'b0;
         flag_free <= 1'b0;
         obs_q     <= '0;
         dflt_hit  <= 1'b0;
      end else begin
         if (at_flag) begin
            flag_free <= line_in;
            lost      <= 1'b0;
            if (own) begin
               if (!acc_req) state <= ARB_IDLE;
            end else if (acc_req && line_in && prio_ok) begin
               state <= ARB_CONTEND;
            end else begin
               state <= ARB_IDLE;
            end
         end
         if (at_addr) begin
            obs_q <= obs_full;
            if (state == ARB_CONTEND && !lost && lost_next) lost <= 1'b1;
            if (addr_last) begin
               dflt_hit <= dflt_cond;
               if (state == ARB_CONTEND) state <= lost_next ? ARB_IDLE : ARB_OWN;
            end
         end
      end
   end
endmodule

// File: rtl/cbus_arbiter.sv
module cbus_arbiter #(
   parameter int FRAME_BITS    = 32,
   parameter int OCTET_POS     = 16,
   parameter int ADDR_W        = 3,
   parameter int FREE_FRAMES   = 2,
   parameter bit MSB_FIRST     = 1'b1,
   parameter bit DEFAULT_OWNER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_sync,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic              line_in,
   output logic              line_out,
   input  logic              stopgo_in,
   output logic              grant,
   output logic              dch_stop
);
   localparam int IW = $clog2(ADDR_W);

   generate
      if (ADDR_W < 2 || ADDR_W > 5) begin : g_bad_addr_w
         $error("cbus_arbiter: ADDR_W must lie in 2..5");
      end
      if (OCTET_POS + 8 > FRAME_BITS) begin : g_bad_octet
         $error("cbus_arbiter: arbitration octet exceeds frame");
      end
      if (FREE_FRAMES < 1) begin : g_bad_free
         $error("cbus_arbiter: FREE_FRAMES must be at least 1");
      end
   endgenerate

   logic          at_flag, at_addr, addr_last;
   logic [IW-1:0] addr_idx;
   logic          prio_ok, own, release_p, dflt_hit;

   cbus_slot_timer #(
      .FRAME_BITS(FRAME_BITS), .OCTET_POS(OCTET_POS), .ADDR_W(ADDR_W)
   ) u_timer (
      .clk(clk), .rst(rst), .frame_sync(frame_sync),
      .at_flag(at_flag), .at_addr(at_addr), .addr_last(addr_last),
      .addr_idx(addr_idx)
   );

   cbus_prio_gate #(.FREE_FRAMES(FREE_FRAMES)) u_prio (
      .clk(clk), .rst(rst), .at_flag(at_flag), .line_in(line_in),
      .release_i(release_p), .prio_ok(prio_ok)
   );

   cbus_contend #(
      .ADDR_W(ADDR_W), .MSB_FIRST(MSB_FIRST), .DEFAULT_OWNER(DEFAULT_OWNER)
   ) u_contend (
      .clk(clk), .rst(rst), .at_flag(at_flag), .at_addr(at_addr),
      .addr_last(addr_last), .addr_idx(addr_idx), .acc_req(acc_req),
      .dev_addr(dev_addr), .line_in(line_in), .prio_ok(prio_ok),
      .line_out(line_out), .own(own), .release_o(release_p),
      .dflt_hit(dflt_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         grant    <= 1'b0;
         dch_stop <= 1'b1;
      end else begin
         if (frame_sync) grant <= own | dflt_hit;
         if (at_flag) dch_stop <= stopgo_in;
      end
   end
endmodule

// File: rtl/cbus_arbiter_chk.sv
module cbus_arbiter_chk (
   input logic clk,
   input logic rst,
   input logic frame_sync,
   input logic acc_req,
   input logic line_out,
   input logic stopgo_in,
   input logic grant,
   input logic dch_stop,
   input logic at_flag,
   input logic at_addr
);
   AST_RESET_STATE: assert property (@(posedge clk)
      $past(rst) |-> (!grant && dch_stop)); // R1

   AST_RECESSIVE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
      (!at_flag && !at_addr) |-> line_out); // R2

   AST_FLAG_BY_OWNER: assert property (@(posedge clk) disable iff (rst)
      (at_flag && !line_out) |-> (grant && acc_req)); // R6

   AST_GRANT_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
      (!$past(frame_sync) && !$past(rst)) |-> $stable(grant)); // R11

   AST_STOPGO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      ($past(at_flag) && !$past(rst)) |-> (dch_stop == $past(stopgo_in))); // R10
endmodule

bind cbus_arbiter cbus_arbiter_chk u_chk (
   .clk(clk), .rst(rst), .frame_sync(frame_sync), .acc_req(acc_req),
   .line_out(line_out), .stopgo_in(stopgo_in), .grant(grant),
   .dch_stop(dch_stop), .at_flag(at_flag), .at_addr(at_addr)
);

// File: tb/test_cbus_arbiter.sv
`timescale 1ns/1ps
module test_cbus_arbiter;
   localparam int FB       = 32;
   localparam int OCT      = 16;
   localparam int FLAG_POS = OCT + 2;
   localparam int ADDR_POS = OCT + 3;
   localparam int NROWS    = 22;
   localparam int WD_CYC   = 100000;

   // row: req, addr, ext_flag, ext_addr, stop, exp_flag_drv, exp_addr_drv, exp_grant, pad
   localparam logic [15:0] VEC [NROWS] = '{
      {1'b0,3'd3,1'b1,3'd7,1'b1, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd3,1'b0,3'd2,1'b0, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b1, 1'b1,3'd3,1'b0,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b0, 1'b0,3'd3,1'b1,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b1, 1'b0,3'd3,1'b1,2'b00},
      {1'b0,3'd3,1'b1,3'd7,1'b0, 1'b1,3'd7,1'b1,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b1, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd3,1'b0,3'd1,1'b0, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b1, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b0, 1'b1,3'd3,1'b0,2'b00},
      {1'b1,3'd3,1'b1,3'd7,1'b1, 1'b0,3'd3,1'b1,2'b00},
      {1'b0,3'd3,1'b1,3'd7,1'b0, 1'b1,3'd7,1'b1,2'b00},
      {1'b0,3'd3,1'b1,3'd7,1'b1, 1'b1,3'd7,1'b0,2'b00},
      {1'b0,3'd3,1'b1,3'd7,1'b0, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd5,1'b1,3'd3,1'b1, 1'b1,3'd7,1'b0,2'b00},
      {1'b1,3'd5,1'b1,3'd7,1'b0, 1'b1,3'd5,1'b0,2'b00},
      {1'b1,3'd5,1'b1,3'd7,1'b1, 1'b0,3'd5,1'b1,2'b00},
      {1'b0,3'd5,1'b1,3'd7,1'b0, 1'b1,3'd7,1'b1,2'b00},
      {1'b0,3'd7,1'b1,3'd7,1'b1, 1'b1,3'd7,1'b0,2'b00},
      {1'b0,3'd7,1'b1,3'd7,1'b0, 1'b1,3'd7,1'b1,2'b00},
      {1'b0,3'd7,1'b0,3'd2,1'b1, 1'b1,3'd7,1'b1,2'b00},
      {1'b0,3'd3,1'b1,3'd7,1'b0, 1'b1,3'd7,1'b0,2'b00}
   };
   localparam string TAG [NROWS] = '{
      "R12","R7","R3","R6","R6","R6","R8","R8","R8","R8","R5",
      "R6","R12","R8","R4","R4","R5","R6","R9","R9","R9","R9"
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_sync = 1'b0;
   logic       acc_req = 1'b0;
   logic [2:0] dev_addr = 3'd0;
   logic       ext_bit = 1'b1;
   logic       stopgo_in = 1'b1;
   logic       line_in, line_out, grant, dch_stop;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   logic       o_flag, o_g_mid, o_g_last;
   logic [2:0] o_addr;
   int         o_bad;

   always #2 clk = ~clk;

   assign line_in = line_out & ext_bit;

   cbus_arbiter #(.FRAME_BITS(FB), .OCTET_POS(OCT)) i_cbus_arbiter (
      .clk(clk), .rst(rst), .frame_sync(frame_sync), .acc_req(acc_req),
      .dev_addr(dev_addr), .line_in(line_in), .line_out(line_out),
      .stopgo_in(stopgo_in), .grant(grant), .dch_stop(dch_stop)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic req, input logic [2:0] addr,
                            input logic eflag, input logic [2:0] eaddr,
                            input logic stop);
      o_bad = 0;
      for (int b = 0; b < FB; b++) begin
         @(negedge clk);
         frame_sync = (b == 0);
         acc_req    = req;
         dev_addr   = addr;
         stopgo_in  = (b == FLAG_POS) ? stop : ~stop;
         if (b == FLAG_POS)                          ext_bit = eflag;
         else if (b >= ADDR_POS && b < ADDR_POS + 3) ext_bit = eaddr[2 - (b - ADDR_POS)];
         else                                        ext_bit = 1'b1;
         #1;
         if (b == FLAG_POS) o_flag = line_out;
         else if (b >= ADDR_POS && b < ADDR_POS + 3) o_addr[2 - (b - ADDR_POS)] = line_out;
         else if (!line_out) o_bad++;
         if (b == 2)      o_g_mid  = grant;
         if (b == FB - 1) o_g_last = grant;
      end
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: state after reset
      check(grant == 1'b0, "R1", grant, 0);
      check(dch_stop == 1'b1, "R1", dch_stop, 1);
      check(line_out == 1'b1, "R1", line_out, 1);

      for (int r = 0; r < NROWS; r++) begin
         logic [15:0] v;
         v = VEC[r];
         run_frame(v[15], v[14:12], v[11], v[10:8], v[7]);
         check(o_flag == v[6], TAG[r], o_flag, v[6]);
         check(o_addr == v[5:3], TAG[r], o_addr, v[5:3]);
         check(o_g_mid == v[2], TAG[r], o_g_mid, v[2]);
         check(o_g_last == o_g_mid, "R11", o_g_last, o_g_mid);
         check(o_bad == 0, "R2", o_bad, 0);
         check(dch_stop == v[7], "R10", dch_stop, v[7]);
      end

      // R1: reset while owning, then contend at once
      run_frame(1'b1, 3'd2, 1'b1, 3'd7, 1'b1);
      check(o_addr == 3'd2, "R3", o_addr, 2);
      run_frame(1'b1, 3'd2, 1'b1, 3'd7, 1'b0);
      check(o_g_mid == 1'b1, "R5", o_g_mid, 1);
      check(o_flag == 1'b0, "R6", o_flag, 0);
      @(negedge clk);
      frame_sync = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(grant == 1'b0, "R1", grant, 0);
      check(dch_stop == 1'b1, "R1", dch_stop, 1);
      check(line_out == 1'b1, "R1", line_out, 1);
      run_frame(1'b1, 3'd2, 1'b1, 3'd7, 1'b0);
      check(o_flag == 1'b1, "R1", o_flag, 1);
      check(o_addr == 3'd2, "R1", o_addr, 2);
      check(o_g_mid == 1'b0, "R1", o_g_mid, 0);
      run_frame(1'b1, 3'd2, 1'b1, 3'd7, 1'b1);
      check(o_g_mid == 1'b1, "R5", o_g_mid, 1);

      // R4: lose against a lower address on the final bit
      run_frame(1'b0, 3'd2, 1'b1, 3'd7, 1'b1);
      run_frame(1'b0, 3'd1, 1'b1, 3'd7, 1'b1);
      run_frame(1'b0, 3'd1, 1'b1, 3'd7, 1'b1);
      run_frame(1'b1, 3'd1, 1'b1, 3'd0, 1'b1);
      check(o_addr == 3'd1, "R4", o_addr, 1);
      run_frame(1'b0, 3'd1, 1'b1, 3'd7, 1'b1);
      check(o_g_mid == 1'b0, "R4", o_g_mid, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule